// File: doc/BRIEF.md
# I2C Interrupt Vector Unit

This block sits beside the protocol engine of an I2C controller and turns its single-cycle event pulses into software-visible interrupt state. Seven event kinds are tracked: arbitration lost, missing acknowledge, access ready, receive data ready, transmit data ready, stop condition seen and addressed as target. Each pulse latches a sticky bit in a status word. An enable mask selects which sticky bits may raise the interrupt line.

Software sees three registers through a simple read/write port. The mask register sits at offset 0x04 and the status register at offset 0x08. The vector register sits at offset 0x28 and reports a small code for the most urgent pending enabled event. Each read of the vector register also retires the event it reported, so a handler can loop on it until it reads zero. Status bits are cleared by writing ones to them. The status word also carries two live bus conditions that never interrupt.

Top module: `irqv_unit`

## Requirements
- R1: A one on `evt_pulse[i]` sets status bit i in the next cycle, and the bit then stays set until it is cleared. The bit positions are: arbitration lost 0, missing acknowledge 1, access ready 2, receive ready 3, transmit ready 4, stop seen 5, addressed as target 6.
- R2: A write to offset 0x08 clears every status bit 6..0 whose `wdata` bit is 1. Status bits whose `wdata` bit is 0 are left unchanged.
- R3: When an event pulse arrives in the same cycle as a clear of the same bit, the bit stays set. The clear may come from a write of one or from a vector read that reports that bit.
- R4: The mask register at offset 0x04 holds `wdata[6:0]` after a write, reads back in bits 6..0 with the upper bits zero, and is 0 after reset.
- R5: `vector_o` shows the code of the lowest-numbered pending status bit whose mask bit is set. The code is the bit index plus one: arbitration lost 1, missing acknowledge 2, access ready 3, receive ready 4, transmit ready 5, stop seen 6, addressed as target 7. When no enabled bit is pending, `vector_o` is 0. Pending bits that are masked off never appear in `vector_o`.
- R6: A read of offset 0x28 returns the current vector code in `rdata` and clears the status bit that the code names. Repeated reads therefore return the pending enabled codes in ascending order and then return 0.
- R7: `irq` is high exactly while at least one status bit is set together with its mask bit. It is a level signal: it stays high until every such bit is cleared.
- R8: Status bit 11 shows `rx_full` and status bit 12 shows `bus_busy` as live values. Neither one affects `irq` or `vector_o`, and writing ones to them has no effect.
- R9: After reset, status bits 6..0, the mask, `irq`, `vector_o` and `rdata` are all 0.
- R10: `rdata` is registered and updates in the cycle after `rd_en`. A read of any unmapped offset returns 0. A write to offset 0x28 changes neither status nor mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pulse | input | 7 | Single-cycle event pulses from the protocol engine, one per status bit |
| rx_full | input | 1 | Live flag: the receive shift register is full |
| bus_busy | input | 1 | Live flag: the bus is busy |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Level interrupt request |
| status_o | output | 16 | Composed status word |
| mask_o | output | 7 | Enable mask |
| vector_o | output | 3 | Current vector code |

## Verification
Two clears compete with the event set path in the same cycle. One is the write-one-to-clear path. The other is the retire-on-vector-read path. The bench raises an event pulse on the exact clock edge where software writes a one to that bit, and again on the edge where a vector read reports that same bit. In both cases it then checks that the status bit is still set and that the vector code still names the event. The read data of the colliding vector read must still carry the code that was reported.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

   // Event bit positions inside the status and mask words.
   localparam int EV_ARB_LOST  = 0;
   localparam int EV_NO_ACK    = 1;
   localparam int EV_ACC_RDY   = 2;
   localparam int EV_RX_RDY    = 3;
   localparam int EV_TX_RDY    = 4;
   localparam int EV_STOP_SEEN = 5;
   localparam int EV_ADDR_HIT  = 6;

   // Register byte offsets (32-bit stride).
   localparam int OFS_MASK = 'h04;
   localparam int OFS_STAT = 'h08;
   localparam int OFS_VEC  = 'h28;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_MASK = 2'd1,
      SEL_STAT = 2'd2,
      SEL_VEC  = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/irqv_prio_pick.sv
// Picks one pending enabled event. With LOW_FIRST the lowest index wins;
// otherwise the highest index wins. Produces a one-hot grant and its code.
module irqv_prio_pick #(
   parameter int EVT_N     = 7,
   parameter int CODE_W    = 3,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [EVT_N-1:0]  pend,
   output logic [EVT_N-1:0]  grant,
   output logic [CODE_W-1:0] code
);

   logic [EVT_N-1:0] pend_ord;
   logic [EVT_N-1:0] grant_ord;
   logic [EVT_N-1:0] seen;

   // Reorder the requests so that the priority chain always scans from index 0.
   for (genvar i = 0; i < EVT_N; i++) begin : g_ord
      localparam int J = LOW_FIRST ? i : (EVT_N - 1 - i);
      assign pend_ord[i] = pend[J];
      assign grant[J]    = grant_ord[i];
   end

   assign seen[0] = 1'b0;
   for (genvar i = 1; i < EVT_N; i++) begin : g_seen
      assign seen[i] = seen[i-1] | pend_ord[i-1];
   end

   assign grant_ord = pend_ord & ~seen;

   always_comb begin
      code = '0;
      for (int i = 0; i < EVT_N; i++) begin
         if (grant[i]) code = code | CODE_W'(i + 1);
      end
   end

endmodule

// File: rtl/irqv_status_bank.sv
// Sticky event flags. A set pulse has priority over both clear sources.
module irqv_status_bank #(
   parameter int EVT_N         = 7,
   parameter bit CLEAR_ON_READ = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_N-1:0] set_bits,
   input  logic [EVT_N-1:0] w1c_bits,
   input  logic [EVT_N-1:0] grant,
   input  logic             vec_rd,
   output logic [EVT_N-1:0] flags
);

   logic [EVT_N-1:0] rd_clr;

   if (CLEAR_ON_READ) begin : g_rdclr
      assign rd_clr = vec_rd ? grant : '0;
   end else begin : g_nordclr
      logic unused_rd;
      assign unused_rd = vec_rd ^ (^grant);
      assign rd_clr = '0;
   end

   for (genvar i = 0; i < EVT_N; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       flags[i] <= 1'b0;
         else if (set_bits[i])             flags[i] <= 1'b1;
         else if (w1c_bits[i] | rd_clr[i]) flags[i] <= 1'b0;
      end
   end

endmodule

// File: rtl/irqv_regport.sv
// Address decode, mask register and registered read data.
module irqv_regport
   import irqv_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int EVT_N  = 7,
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] status_word,
   input  logic [CODE_W-1:0] vec_code,
   output logic [EVT_N-1:0]  mask_q,
   output logic [EVT_N-1:0]  w1c_bits,
   output logic              vec_rd,
   output logic [DATA_W-1:0] rdata_q
);

   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(OFS_VEC);

   reg_sel_e          sel;
   logic [DATA_W-1:0] rd_mux;
   logic              unused_hi;

   assign unused_hi = ^wdata[DATA_W-1:EVT_N];

   always_comb begin
      case (addr)
         A_MASK:  sel = SEL_MASK;
         A_STAT:  sel = SEL_STAT;
         A_VEC:   sel = SEL_VEC;
         default: sel = SEL_NONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           mask_q <= '0;
      else if (wr_en && (sel == SEL_MASK))  mask_q <= wdata[EVT_N-1:0];
   end

   assign w1c_bits = (wr_en && (sel == SEL_STAT)) ? wdata[EVT_N-1:0] : '0;
   assign vec_rd   = rd_en && (sel == SEL_VEC);

   always_comb begin
      case (sel)
         SEL_MASK: rd_mux = DATA_W'(mask_q);
         SEL_STAT: rd_mux = status_word;
         SEL_VEC:  rd_mux = DATA_W'(vec_code);
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_q <= '0;
      else if (rd_en) rdata_q <= rd_mux;
   end

endmodule

// File: rtl/irqv_unit.sv
module irqv_unit #(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 16,
   parameter int EVT_N         = 7,
   parameter int CODE_W        = 3,
   parameter int FULL_BIT      = 11,
   parameter int BUSY_BIT      = 12,
   parameter bit LOW_FIRST     = 1'b1,
   parameter bit CLEAR_ON_READ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EVT_N-1:0]  evt_pulse,
   input  logic              rx_full,
   input  logic              bus_busy,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq,
   output logic [DATA_W-1:0] status_o,
   output logic [EVT_N-1:0]  mask_o,
   output logic [CODE_W-1:0] vector_o
);

   // Elaboration-time parameter checks.
   if ((1 << CODE_W) <= EVT_N) begin : g_bad_code
      $error("CODE_W too narrow for EVT_N event codes");
   end
   if (EVT_N > FULL_BIT || EVT_N > BUSY_BIT) begin : g_bad_evt
      $error("live flag bits overlap the event bits");
   end
   if (FULL_BIT == BUSY_BIT) begin : g_bad_live
      $error("FULL_BIT and BUSY_BIT must differ");
   end
   if (FULL_BIT >= DATA_W || BUSY_BIT >= DATA_W) begin : g_bad_data
      $error("live flag bits outside the data word");
   end
   if (EVT_N < 1) begin : g_bad_n
      $error("EVT_N must be at least 1");
   end

   logic [EVT_N-1:0]  flags;
   logic [EVT_N-1:0]  pend;
   logic [EVT_N-1:0]  grant;
   logic [EVT_N-1:0]  w1c_bits;
   logic [CODE_W-1:0] code;
   logic              vec_rd;
   logic [DATA_W-1:0] word;

   irqv_status_bank #(
      .EVT_N         (EVT_N),
      .CLEAR_ON_READ (CLEAR_ON_READ)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits (evt_pulse),
      .w1c_bits (w1c_bits),
      .grant    (grant),
      .vec_rd   (vec_rd),
      .flags    (flags)
   );

   assign pend = flags & mask_o;

   irqv_prio_pick #(
      .EVT_N     (EVT_N),
      .CODE_W    (CODE_W),
      .LOW_FIRST (LOW_FIRST)
   ) u_pick (
      .pend  (pend),
      .grant (grant),
      .code  (code)
   );

   // Compose the readable status word: events low, two live flags above.
   for (genvar b = 0; b < DATA_W; b++) begin : g_word
      if (b < EVT_N) begin : g_evt
         assign word[b] = flags[b];
      end else if (b == FULL_BIT) begin : g_full
         assign word[b] = rx_full;
      end else if (b == BUSY_BIT) begin : g_busy
         assign word[b] = bus_busy;
      end else begin : g_zero
         assign word[b] = 1'b0;
      end
   end

   irqv_regport #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .EVT_N  (EVT_N),
      .CODE_W (CODE_W)
   ) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .rd_en       (rd_en),
      .addr        (addr),
      .wdata       (wdata),
      .status_word (word),
      .vec_code    (code),
      .mask_q      (mask_o),
      .w1c_bits    (w1c_bits),
      .vec_rd      (vec_rd),
      .rdata_q     (rdata)
   );

   assign irq      = |pend;
   assign status_o = word;
   assign vector_o = code;

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
   import irqv_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int EVT_N  = 7,
   parameter int CODE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [EVT_N-1:0]  evt_pulse,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic              irq,
   input logic [DATA_W-1:0] status_o,
   input logic [EVT_N-1:0]  mask_o,
   input logic [CODE_W-1:0] vector_o
);

   logic [EVT_N-1:0] en_pend;
   logic             quiet;

   assign en_pend = status_o[EVT_N-1:0] & mask_o;
   assign quiet   = (evt_pulse == '0)
                  && !(wr_en && (addr == ADDR_W'(OFS_STAT)))
                  && !(rd_en && (addr == ADDR_W'(OFS_VEC)));

   // R1 / R3: a pulse always leaves its bit set, whatever clear arrives with it
   a_r1_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pulse != '0) |=> ((status_o[EVT_N-1:0] & $past(evt_pulse)) == $past(evt_pulse)));

   // R2: without a pulse or a clear source the event bits hold
   a_r2_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |=> $stable(status_o[EVT_N-1:0]));

   // R4: mask changes only through a mask write
   a_r4_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (addr == ADDR_W'(OFS_MASK))) |=> $stable(mask_o));

   // R7: irq agrees with the vector encoder
   a_r7_irq_vec: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (vector_o != '0));
   a_r7_noirq_vec: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> (vector_o == '0));

   // R5: the reported event is pending, enabled and the lowest such
   a_r5_named_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (vector_o != '0) |-> (((en_pend >> (vector_o - CODE_W'(1))) & EVT_N'(1)) != '0));
   a_r5_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      (vector_o != '0) |-> ((en_pend & ((EVT_N'(1) << (vector_o - CODE_W'(1))) - EVT_N'(1))) == '0));

   always_comb begin
      if (rst_n) begin
         a_r5_range: assert (int'(vector_o) <= EVT_N);
      end
   end

endmodule

bind irqv_unit irqv_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .EVT_N  (EVT_N),
   .CODE_W (CODE_W)
) u_irqv_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_pulse (evt_pulse),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .addr      (addr),
   .irq       (irq),
   .status_o  (status_o),
   .mask_o    (mask_o),
   .vector_o  (vector_o)
);

// File: tb/test_irqv_unit.sv
`timescale 1ns/1ps
module test_irqv_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  evt_pulse = '0;
   logic        rx_full = 1'b0;
   logic        bus_busy = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq;
   logic [15:0] status_o;
   logic [6:0]  mask_o;
   logic [2:0]  vector_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   irqv_unit i_irqv_unit (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .rx_full(rx_full),
      .bus_busy(bus_busy), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq), .status_o(status_o),
      .mask_o(mask_o), .vector_o(vector_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [7:0] a, output logic [15:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic fire(input logic [6:0] bits);
      @(negedge clk);
      evt_pulse = bits;
      @(negedge clk);
      evt_pulse = '0;
   endtask

   task automatic wipe();
      reg_wr(8'h08, 16'h007F);
   endtask

   task automatic t_reset();
      chk("R9 status", status_o, 32'h0);
      chk("R9 mask", mask_o, 32'h0);
      chk("R9 irq", irq, 32'h0);
      chk("R9 vector", vector_o, 32'h0);
      chk("R9 rdata", rdata, 32'h0);
   endtask

   task automatic t_set_and_mask();
      logic [15:0] d;
      fire(7'h11);
      reg_rd(8'h08, d);
      chk("R1 status after pulses", d, 32'h0011);
      chk("R7 irq masked", irq, 32'h0);
      chk("R5 vector masked", vector_o, 32'h0);
      reg_wr(8'h04, 16'hFFFF);
      reg_rd(8'h04, d);
      chk("R4 mask readback", d, 32'h007F);
      chk("R7 irq enabled", irq, 32'h1);
      chk("R5 vector lowest", vector_o, 32'h1);
      wipe();
      chk("R7 irq after clear", irq, 32'h0);
   endtask

   task automatic t_walk();
      logic [15:0] d;
      fire(7'h7F);
      for (int k = 1; k <= 7; k++) begin
         reg_rd(8'h28, d);
         chk($sformatf("R6 walk read %0d", k), d, k);
      end
      reg_rd(8'h28, d);
      chk("R6 walk end", d, 32'h0);
      chk("R6 status empty", status_o[6:0], 32'h0);
      chk("R7 irq after walk", irq, 32'h0);
   endtask

   task automatic t_w1c();
      logic [15:0] d;
      fire(7'h2C);
      reg_wr(8'h08, 16'h0024);
      reg_rd(8'h08, d);
      chk("R2 partial clear", d, 32'h0008);
      reg_wr(8'h08, 16'h0000);
      chk("R2 zero write", status_o[6:0], 32'h08);
      wipe();
   endtask

   task automatic t_collide();
      logic [15:0] d;
      fire(7'h08);
      @(negedge clk);
      evt_pulse = 7'h08; wr_en = 1'b1; addr = 8'h08; wdata = 16'h0008;
      @(negedge clk);
      evt_pulse = '0; wr_en = 1'b0;
      chk("R3 pulse beats w1c", status_o[6:0], 32'h08);
      @(negedge clk);
      evt_pulse = 7'h08; rd_en = 1'b1; addr = 8'h28;
      @(negedge clk);
      evt_pulse = '0; rd_en = 1'b0;
      d = rdata;
      chk("R3 colliding vector read data", d, 32'h4);
      chk("R3 pulse beats read clear", status_o[6:0], 32'h08);
      chk("R3 vector still named", vector_o, 32'h4);
      wipe();
   endtask

   task automatic t_priority_mask();
      logic [15:0] d;
      reg_wr(8'h04, 16'h0060);
      fire(7'h61);
      chk("R5 masked low bit skipped", vector_o, 32'h6);
      chk("R7 irq level", irq, 32'h1);
      reg_rd(8'h28, d);
      chk("R6 read code", d, 32'h6);
      chk("R5 next code", vector_o, 32'h7);
      chk("R6 masked bit kept", status_o[6:0], 32'h41);
      wipe();
      reg_wr(8'h04, 16'h007F);
   endtask

   task automatic t_live();
      logic [15:0] d;
      @(negedge clk);
      bus_busy = 1'b1; rx_full = 1'b1;
      reg_rd(8'h08, d);
      chk("R8 live bits", d, 32'h1800);
      chk("R8 no irq", irq, 32'h0);
      chk("R8 no vector", vector_o, 32'h0);
      reg_wr(8'h08, 16'h1800);
      chk("R8 w1c ignored", status_o, 32'h1800);
      @(negedge clk);
      bus_busy = 1'b0; rx_full = 1'b0;
      @(negedge clk);
      chk("R8 live follow", status_o, 32'h0000);
   endtask

   task automatic t_misc();
      logic [15:0] d;
      fire(7'h02);
      reg_wr(8'h28, 16'h007F);
      chk("R10 vector write ignored status", status_o[6:0], 32'h02);
      chk("R10 vector write ignored mask", mask_o, 32'h7F);
      reg_rd(8'h30, d);
      chk("R10 unmapped read", d, 32'h0);
      @(negedge clk);
      rd_en = 1'b1; addr = 8'h28;
      #1 chk("R10 rdata not yet updated", rdata, 32'h0);
      @(negedge clk);
      rd_en = 1'b0;
      chk("R10 rdata next cycle", rdata, 32'h2);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_set_and_mask();
      t_walk();
      t_w1c();
      t_collide();
      t_priority_mask();
      t_live();
      t_misc();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule